// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit

This block is a stateless N-bit arithmetic logic unit (8 bits by default) that sits in a processor datapath between the operand multiplexers and the status register. It adds or subtracts two operand words, or combines them bitwise with AND, OR or XOR, and reports four condition flags alongside the result. The flags are zero, carry, overflow and negative.

The adder is a literal chain of full-adder cells. Each cell is made of two half adders and an OR gate, and the carry travels from bit 0 upward. Subtraction does not need a second adder. The second operand is inverted on its way into the same chain, and the chain's carry-in is tied high, so the chain computes A + ~B + 1. Signed overflow comes from comparing the carry that enters the top cell with the carry that leaves it.

A 2-bit select picks which result reaches the output. A separate subtract line sets the adder's mode. Callers feed both from an instruction decoder and register the outputs themselves.

Top module: `rc_alu`

## Requirements
- R1: With op_sel = 2'b00 and sub_en = 0, result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R2: With op_sel = 2'b00 and sub_en = 1, result equals (opnd_a + ~opnd_b + 1) modulo 2^WIDTH, which is opnd_a − opnd_b.
- R3: op_sel = 2'b01 gives opnd_a AND opnd_b, 2'b10 gives OR, and 2'b11 gives XOR. For these three codes sub_en has no effect on any output.
- R4: flag_z is 1 exactly when every bit of result is 0, for every op_sel code.
- R5: With op_sel = 2'b00, flag_c is the carry out of the most significant adder cell. In addition it is the unsigned carry. In subtraction it is 1 when no borrow occurs, that is when opnd_a >= opnd_b unsigned. For any other op_sel, flag_c is 0.
- R6: With op_sel = 2'b00, flag_v is 1 exactly when the carry into the most significant cell differs from the carry out of it. This equals two's-complement overflow of the add or subtract. For any other op_sel, flag_v is 0.
- R7: flag_n equals result[WIDTH-1] for every op_sel code.
- R8: The block holds no state. Every output settles from the present inputs alone, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand; inverted in subtract mode |
| op_sel | input | 2 | 00 arithmetic, 01 AND, 10 OR, 11 XOR |
| sub_en | input | 1 | Selects subtraction when op_sel is 00 |
| result | output | WIDTH | Selected result word |
| flag_z | output | 1 | Result is all zeros |
| flag_c | output | 1 | Carry out of top adder cell; 0 for logic ops |
| flag_v | output | 1 | Signed overflow; 0 for logic ops |
| flag_n | output | 1 | Most significant bit of result |

## Verification
The block has no internal state, so any wrong internal signal shows at the ports as soon as the inputs settle. Examples are a broken carry link, a missing inversion or a misrouted select. There is no clock latency to wait out. A fault in one chain cell corrupts the sum only for operand pairs whose carry passes that bit. For that reason every pair of 8-bit operands is driven in both add and subtract mode and compared against a wide-integer model. Logic codes are swept with sub_en toggled to show that the mode line never leaks into those results.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;

    typedef enum logic [1:0] {
        OP_ARITH = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_XOR   = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic v;
        logic n;
    } alu_flags_t;

    // Carry into the top cell vs. carry out of it.
    function automatic logic sign_overflow(input logic c_into_msb, input logic c_out_msb);
        return c_into_msb ^ c_out_msb;
    endfunction

endpackage

// File: rtl/rc_half_add.sv
module rc_half_add (
    input  logic x,
    input  logic y,
    output logic s,
    output logic co
);
    assign s  = x ^ y;
    assign co = x & y;
endmodule

// File: rtl/rc_full_add.sv
module rc_full_add (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic s_lo, c_lo, c_hi;

    rc_half_add u_ha_lo (.x(x),    .y(y),  .s(s_lo), .co(c_lo));
    rc_half_add u_ha_hi (.x(s_lo), .y(ci), .s(s),    .co(c_hi));

    assign co = c_lo | c_hi;
endmodule

// File: rtl/rc_chain.sv
module rc_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             c_top_in
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;
    assign carry[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        rc_full_add u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign c_out    = carry[WIDTH];
    assign c_top_in = carry[MSB];
endmodule

// File: rtl/rc_logic_unit.sv
module rc_logic_unit
    import rc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = x & y;
            OP_OR:   res = x | y;
            OP_XOR:  res = x ^ y;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import rc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [1:0]       op_sel,
    input  logic             sub_en,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_n
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             c_out, c_top_in;
    logic             is_arith;
    alu_flags_t       flags;

    assign op       = alu_op_e'(op_sel);
    assign is_arith = (op == OP_ARITH);

    // One inverter per bit turns the adder into a subtractor.
    assign b_eff = sub_en ? ~opnd_b : opnd_b;

    rc_chain #(.WIDTH(WIDTH)) u_chain (
        .x        (opnd_a),
        .y        (b_eff),
        .c_in     (sub_en),
        .sum      (arith_res),
        .c_out    (c_out),
        .c_top_in (c_top_in)
    );

    rc_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .x   (opnd_a),
        .y   (opnd_b),
        .op  (op),
        .res (logic_res)
    );

    assign result = is_arith ? arith_res : logic_res;

    always_comb begin
        flags.z = ~|result;
        flags.n = result[MSB];
        flags.c = is_arith & c_out;
        flags.v = is_arith & sign_overflow(c_top_in, c_out);
    end

    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_v = flags.v;
    assign flag_n = flags.n;
endmodule

// File: rtl/rc_alu_check.sv
module rc_alu_check #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [1:0]       op_sel,
    input logic             sub_en,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_n
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        assert_zero_R4: assert (flag_z == (result == '0));
        assert_neg_R7:  assert (flag_n == result[MSB]);
        if (op_sel != 2'b00) begin
            assert_logic_nocarry_R5: assert (!flag_c);
            assert_logic_noovf_R6:   assert (!flag_v);
        end
        if (op_sel == 2'b01) begin
            assert_and_R3: assert (result == (opnd_a & opnd_b));
        end
        if (op_sel == 2'b00 && sub_en) begin
            assert_sub_noborrow_R5: assert (flag_c == (opnd_a >= opnd_b));
            assert_sub_ovf_R6: assert (flag_v ==
                ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])));
        end
        if (op_sel == 2'b00 && !sub_en) begin
            assert_add_ovf_R6: assert (flag_v ==
                ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])));
        end
    end
endmodule

bind rc_alu rc_alu_check #(.WIDTH(WIDTH)) u_rc_alu_check (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .sub_en (sub_en),
    .result (result),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_v (flag_v),
    .flag_n (flag_n)
);

// File: tb/rc_alu_test.sv
module rc_alu_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0] opnd_a, opnd_b, result;
    logic [1:0]   op_sel;
    logic         sub_en;
    logic         flag_z, flag_c, flag_v, flag_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    rc_alu #(.WIDTH(W)) uut (
        .opnd_a (opnd_a), .opnd_b (opnd_b), .op_sel (op_sel), .sub_en (sub_en),
        .result (result), .flag_z (flag_z), .flag_c (flag_c),
        .flag_v (flag_v), .flag_n (flag_n)
    );

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [1:0] sel;
        logic       sub;
        logic [7:0] res;
        logic [3:0] zcvn;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{8'h7F, 8'h01, 2'b00, 1'b0, 8'h80, 4'b0011},  // R1 R6 signed overflow
        '{8'hFF, 8'h01, 2'b00, 1'b0, 8'h00, 4'b1100},  // R1 R5 unsigned wrap
        '{8'h80, 8'h80, 2'b00, 1'b0, 8'h00, 4'b1110},  // R1 R6 negative overflow
        '{8'h12, 8'h34, 2'b00, 1'b0, 8'h46, 4'b0000},  // R1 plain
        '{8'h05, 8'h03, 2'b00, 1'b1, 8'h02, 4'b0100},  // R2 R5 no borrow
        '{8'h03, 8'h05, 2'b00, 1'b1, 8'hFE, 4'b0001},  // R2 R5 borrow
        '{8'h80, 8'h01, 2'b00, 1'b1, 8'h7F, 4'b0110},  // R2 R6
        '{8'h42, 8'h42, 2'b00, 1'b1, 8'h00, 4'b1100},  // R2 R4 equal
        '{8'h7F, 8'hFF, 2'b00, 1'b1, 8'h80, 4'b0011},  // R2 R6
        '{8'h00, 8'h00, 2'b00, 1'b1, 8'h00, 4'b1100},  // R2 zero minus zero
        '{8'hF0, 8'h0F, 2'b01, 1'b1, 8'h00, 4'b1000},  // R3 AND, sub ignored
        '{8'h80, 8'h01, 2'b10, 1'b1, 8'h81, 4'b0001},  // R3 OR, sub ignored
        '{8'hAA, 8'hFF, 2'b11, 1'b0, 8'h55, 4'b0000},  // R3 XOR
        '{8'h5A, 8'h5A, 2'b11, 1'b1, 8'h00, 4'b1000}   // R3 R4 XOR zero
    };

    task automatic check(input string req, input logic [W-1:0] exp_res,
                         input logic [3:0] exp_f);
        logic [3:0] got_f;
        got_f = {flag_z, flag_c, flag_v, flag_n};
        n_tests++;
        if (result !== exp_res || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h sel=%b sub=%b: got res=%h zcvn=%b, exp res=%h zcvn=%b",
                     req, opnd_a, opnd_b, op_sel, sub_en, result, got_f, exp_res, exp_f);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] s, input logic m);
        opnd_a = a; opnd_b = b; op_sel = s; sub_en = m;
        #1;
    endtask

    // Reference model: wide integer arithmetic, independent of the cell chain.
    task automatic model(output logic [W-1:0] r, output logic [3:0] f);
        logic [W:0] wide;
        logic c, v;
        c = 1'b0; v = 1'b0;
        case (op_sel)
            2'b00: begin
                if (sub_en) begin
                    wide = {1'b0, opnd_a} - {1'b0, opnd_b};
                    r = wide[W-1:0];
                    c = (opnd_a >= opnd_b);
                    v = (opnd_a[W-1] != opnd_b[W-1]) && (r[W-1] != opnd_a[W-1]);
                end else begin
                    wide = {1'b0, opnd_a} + {1'b0, opnd_b};
                    r = wide[W-1:0];
                    c = wide[W];
                    v = (opnd_a[W-1] == opnd_b[W-1]) && (r[W-1] != opnd_a[W-1]);
                end
            end
            2'b01:   r = opnd_a & opnd_b;
            2'b10:   r = opnd_a | opnd_b;
            default: r = opnd_a ^ opnd_b;
        endcase
        f = {(r == '0), c, v, r[W-1]};
    endtask

    initial begin
        logic [W-1:0] er;
        logic [3:0]   ef;

        // Reset-time state: all-zero inputs give a zero result with Z set (R4, R8).
        apply('0, '0, 2'b00, 1'b0);
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #3;
        check("R8 idle state", 8'h00, 4'b1000);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].a, TBL[i].b, TBL[i].sel, TBL[i].sub);
            check("R1/R2/R3 table", TBL[i].res, TBL[i].zcvn);
        end

        // Exhaustive sweep of add (R1) and subtract (R2) with all flags (R4 R5 R6 R7).
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(a[W-1:0], b[W-1:0], 2'b00, m[0]);
                    model(er, ef);
                    check(m[0] ? "R2 sweep sub" : "R1 sweep add", er, ef);
                end
            end
        end

        // Logic codes with sub_en toggled: sub_en must not matter (R3, R5 R6 forced to 0).
        for (int s = 1; s < 4; s++) begin
            for (int a = 0; a < 256; a += 7) begin
                for (int b = 0; b < 256; b += 5) begin
                    for (int m = 0; m < 2; m++) begin
                        apply(a[W-1:0], b[W-1:0], s[1:0], m[0]);
                        model(er, ef);
                        check("R3 logic sweep", er, ef);
                    end
                end
            end
        end

        // R8: output follows input change without any clock edge.
        @(negedge clk);
        opnd_a = 8'h01; opnd_b = 8'h01; op_sel = 2'b00; sub_en = 1'b0;
        #2;
        check("R8 no clock needed", 8'h02, 4'b0000);
        opnd_b = 8'hFF;
        #2;
        check("R8 settles on change", 8'h00, 4'b1100);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule